// File: doc/BRIEF.md
# Serial Configuration and Status Register Port

This block is a four-wire serial slave (active-low select, serial clock, data in, data out with an output enable) that gives a host controller read and write access to a bank of per-channel command registers for a multi-channel line interface. Each channel owns eight register slots. Slot 0 is a read-only view of that channel's live alarm inputs. Slot 1 holds the transmit control bits. Slots 2 to 7 are general 8-bit configuration registers whose contents drive the block's configuration outputs.

A frame has 16 bits. It carries a direction flag, a 6-bit register address, one ignored spacer bit and an 8-bit data word. The address and the data word are both sent least significant bit first. The serial pins are oversampled by the system clock through two-stage synchronizers, so the serial clock must be much slower than the system clock. Writes commit only when a frame completes. Reads present their data on the output during the second half of the frame. An active-low register reset input returns every writable register to zero without resetting the serial logic.

Top module: `sra_port`

## Requirements
- R1: While spi_cs_n is high, no frame is in progress. A frame that is cut short by spi_cs_n rising before its 16th serial clock rising edge changes no register.
- R2: Bits are sampled on serial clock rising edges in this order: bit 0 is the direction flag (1 = read, 0 = write), bits 1 to 6 are the address LSB first, bit 7 is ignored, and bits 8 to 15 are the data LSB first.
- R3: Address bits [5:3] select the channel (0 to NCH-1) and bits [2:0] select the slot. A read of an address whose channel field is NCH or above returns 0, and a write to such an address is ignored.
- R4: Slot 0 is read-only and reads {3'b000, lol, los, alos, dlos, dmo}, taken from the alarm inputs when the address is complete. A write to slot 0 changes nothing.
- R5: Slot 1 maps bit 0 to tx_bin, bit 1 to tx_lev, bit 2 to tx_clkinv, bit 3 to tx_ones and bit 4 to tx_off of that channel. Its bits 7:5 are not stored and read as 0.
- R6: Slots 2 to 7 are full 8-bit read/write registers. Slot s of channel c appears on cfg_regs[((c*6)+(s-2))*8 +: 8].
- R7: In a read frame, spi_sdo changes on serial clock falling edges. Data bit i is valid before the serial clock rising edge that samples frame bit 8+i.
- R8: A write takes effect only after the 16th rising edge of its frame. The outputs hold their values while the select is idle.
- R9: Driving reg_rst_n low (or rst_n low) clears every writable register to 0 on the next clock edge. Register reset takes priority over a write in the same cycle.
- R10: spi_sdo_oe is high while the synchronized select is low and low while it is high. spi_sdo is 0 while the select is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| reg_rst_n | input | 1 | Synchronous active-low clear of the writable registers |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo (drive when high) |
| alm_lol | input | NCH | Loss-of-lock alarm per channel |
| alm_los | input | NCH | Loss-of-signal alarm per channel |
| alm_alos | input | NCH | Analog loss-of-signal alarm per channel |
| alm_dlos | input | NCH | Digital loss-of-signal alarm per channel |
| alm_dmo | input | NCH | Drive-monitor alarm per channel |
| tx_off | output | NCH | Transmitter off control per channel |
| tx_ones | output | NCH | Transmit all-ones control per channel |
| tx_clkinv | output | NCH | Transmit clock invert control per channel |
| tx_lev | output | NCH | Transmit level control per channel |
| tx_bin | output | NCH | Transmit bipolar-input control per channel |
| cfg_regs | output | NCH*6*8 | Flattened contents of slots 2 to 7 of all channels |

## Verification
On every cycle the assertions check four things: the output enable and the data output stay quiet once the select has been idle for a few cycles, the enable is high during a held select, the configuration outputs hold steady while the select is idle, and they read zero right after a register reset. The bench scenarios cover the rest. These are the bit ordering of the address and data, the channel and slot decode, the status capture in slot 0, the masking of slot 1, the unmapped-address zero, the falling-edge timing of read data, and the rejection of frames that stop short. Random frames over mapped and unmapped addresses are compared against a bench model of the register file.

// File: rtl/sra_pkg.sv
// Package: shared field layouts for the serial register access port.
// Assumes five alarm bits and five transmit control bits per channel.
package sra_pkg;
    localparam int STAT_W = 5;
    localparam int CTL1_W = 5;

    // Slot 0 layout, MSB first: lol, los, alos, dlos, dmo
    typedef struct packed {
        logic lol;
        logic los;
        logic alos;
        logic dlos;
        logic dmo;
    } stat_t;

    // Slot 1 layout, MSB first: off, ones, clkinv, lev, bin
    typedef struct packed {
        logic off;
        logic ones;
        logic clkinv;
        logic lev;
        logic bin;
    } ctl1_t;
endpackage

// File: rtl/sra_sync.sv
// Module: two-stage synchronizer for a bundle of asynchronous pins.
// Assumes the pins change slowly compared with clk; RST_VAL gives idle levels.
module sra_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two flops in series to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/sra_frame.sv
// Module: serial frame engine. It counts rising edges of the synchronized serial
// clock, assembles flag, address and data LSB first, issues one write strobe at
// frame end and shifts read data out on falling edges.
// Assumes inputs come from sra_sync, so all of them carry the same delay.
module sra_frame #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] acc_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int FL = 1 + AW + 1 + DW;
    localparam int CW = $clog2(FL + 1);
    localparam logic [CW-1:0] C_FL   = CW'(FL);
    localparam logic [CW-1:0] C_LAST = CW'(FL - 1);
    localparam logic [CW-1:0] C_AW   = CW'(AW);
    localparam logic [CW-1:0] C_GAP  = CW'(AW + 1);

    logic [CW-1:0] cnt_q;
    logic          rd_q;
    logic          sclk_q;
    logic          out_vld_q;
    logic [DW-1:0] din_q;
    logic [DW-1:0] dout_q;
    logic          rise;
    logic          fall;

    // Serial clock edge detection against the previous sample
    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

    // Output enable follows the synchronized select
    assign sdo_oe = cs_act;

    // Frame assembly, write strobe and read shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rd_q      <= 1'b0;
            sclk_q    <= 1'b0;
            out_vld_q <= 1'b0;
            din_q     <= '0;
            dout_q    <= '0;
            acc_addr  <= '0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            sdo       <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            sclk_q <= sclk_s;
            if (!cs_act) begin
                cnt_q     <= '0;
                out_vld_q <= 1'b0;
                sdo       <= 1'b0;
            end else begin
                if (rise && cnt_q < C_FL) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == '0) begin
                        rd_q <= sdi_s;
                    end else if (cnt_q <= C_AW) begin
                        acc_addr <= {sdi_s, acc_addr[AW-1:1]};
                    end else if (cnt_q > C_GAP) begin
                        din_q <= {sdi_s, din_q[DW-1:1]};
                    end
                    if (cnt_q == C_GAP && rd_q) begin
                        dout_q    <= rd_data;
                        out_vld_q <= 1'b1;
                    end
                    if (cnt_q == C_LAST && !rd_q) begin
                        wr_en   <= 1'b1;
                        wr_data <= {sdi_s, din_q[DW-1:1]};
                    end
                end
                if (fall && out_vld_q) begin
                    sdo    <= dout_q[0];
                    dout_q <= {1'b0, dout_q[DW-1:1]};
                end
            end
        end
    end
endmodule

// File: rtl/sra_regbank.sv
// Module: per-channel register file. Slot 0 is the live status view, slot 1 is the
// masked transmit control, slots 2 and up are full-width configuration registers.
// Assumes alarm inputs are synchronous to clk and NREG is a power of two >= 4.
module sra_regbank
    import sra_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int NREG = 8,
    parameter int AW   = 6,
    parameter int DW   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              acc_addr,
    input  logic [DW-1:0]              wr_data,
    input  logic [NCH*STAT_W-1:0]      status,
    output logic [DW-1:0]              rd_data,
    output logic [NCH*CTL1_W-1:0]      ctl1_flat,
    output logic [NCH*(NREG-2)*DW-1:0] cfg_flat
);
    localparam int RB  = $clog2(NREG);
    localparam int CHB = AW - RB;
    localparam int NCF = NREG - 2;

    logic [RB-1:0]  slot;
    logic [CHB-1:0] chan;

    assign slot = acc_addr[RB-1:0];
    assign chan = acc_addr[AW-1:RB];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic          sel;
        logic [CTL1_W-1:0] ctl1_q;
        logic [DW-1:0] cfg_q [NCF];

        assign sel = wr_en && (chan == CHB'(c));
        assign ctl1_flat[c*CTL1_W +: CTL1_W] = ctl1_q;

        // Slot 1 storage: only the defined control bits are kept
        always_ff @(posedge clk) begin
            if (!rst_n || !reg_rst_n) begin
                ctl1_q <= '0;
            end else if (sel && slot == RB'(1)) begin
                ctl1_q <= wr_data[CTL1_W-1:0];
            end
        end

        for (genvar r = 0; r < NCF; r++) begin : g_cfg
            assign cfg_flat[(c*NCF + r)*DW +: DW] = cfg_q[r];

            // Slot r+2 storage: full-width configuration byte
            always_ff @(posedge clk) begin
                if (!rst_n || !reg_rst_n) begin
                    cfg_q[r] <= '0;
                end else if (sel && slot == RB'(r + 2)) begin
                    cfg_q[r] <= wr_data;
                end
            end
        end
    end

    // Read multiplexer: unmapped channels return zero
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (chan == CHB'(c)) begin
                if (slot == RB'(0)) begin
                    rd_data = {{(DW-STAT_W){1'b0}}, status[c*STAT_W +: STAT_W]};
                end else if (slot == RB'(1)) begin
                    rd_data = {{(DW-CTL1_W){1'b0}}, ctl1_flat[c*CTL1_W +: CTL1_W]};
                end else begin
                    for (int r = 0; r < NCF; r++) begin
                        if (slot == RB'(r + 2)) begin
                            rd_data = cfg_flat[(c*NCF + r)*DW +: DW];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sra_port.sv
// Module: top of the serial register access port. It synchronizes the serial pins,
// runs the frame engine and maps the register file onto named control outputs.
// Assumes the serial clock half-period is at least five system clock cycles.
module sra_port
    import sra_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int NREG = 8,
    parameter int AW   = 6,
    parameter int DW   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_rst_n,
    input  logic                       spi_cs_n,
    input  logic                       spi_sclk,
    input  logic                       spi_sdi,
    output logic                       spi_sdo,
    output logic                       spi_sdo_oe,
    input  logic [NCH-1:0]             alm_lol,
    input  logic [NCH-1:0]             alm_los,
    input  logic [NCH-1:0]             alm_alos,
    input  logic [NCH-1:0]             alm_dlos,
    input  logic [NCH-1:0]             alm_dmo,
    output logic [NCH-1:0]             tx_off,
    output logic [NCH-1:0]             tx_ones,
    output logic [NCH-1:0]             tx_clkinv,
    output logic [NCH-1:0]             tx_lev,
    output logic [NCH-1:0]             tx_bin,
    output logic [NCH*(NREG-2)*DW-1:0] cfg_regs
);
    logic [2:0]               pins_s;
    logic                     cs_act;
    logic [AW-1:0]            acc_addr;
    logic                     wr_en;
    logic [DW-1:0]            wr_data;
    logic [DW-1:0]            rd_data;
    logic [NCH*STAT_W-1:0]    status;
    logic [NCH*CTL1_W-1:0]    ctl1_flat;

    // Pin order in the bundle: {cs_n, sclk, sdi}; idle levels cs_n=1, sclk=0
    sra_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_sdi}),
        .q     (pins_s)
    );

    assign cs_act = ~pins_s[2];

    sra_frame #(.AW(AW), .DW(DW)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .rd_data  (rd_data),
        .acc_addr (acc_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sdo      (spi_sdo),
        .sdo_oe   (spi_sdo_oe)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_map
        stat_t st;
        ctl1_t ct;
        assign st = '{lol: alm_lol[c], los: alm_los[c], alos: alm_alos[c],
                      dlos: alm_dlos[c], dmo: alm_dmo[c]};
        assign status[c*STAT_W +: STAT_W] = st;
        assign ct = ctl1_flat[c*CTL1_W +: CTL1_W];
        assign tx_off[c]    = ct.off;
        assign tx_ones[c]   = ct.ones;
        assign tx_clkinv[c] = ct.clkinv;
        assign tx_lev[c]    = ct.lev;
        assign tx_bin[c]    = ct.bin;
    end

    sra_regbank #(.NCH(NCH), .NREG(NREG), .AW(AW), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rst_n (reg_rst_n),
        .wr_en     (wr_en),
        .acc_addr  (acc_addr),
        .wr_data   (wr_data),
        .status    (status),
        .rd_data   (rd_data),
        .ctl1_flat (ctl1_flat),
        .cfg_flat  (cfg_regs)
    );
endmodule

// File: rtl/sra_port_chk.sv
// Module: assertion checker bound to sra_port. It watches only ports and uses
// its own counters for elapsed idle, active and post-reset cycles.
module sra_port_chk #(
    parameter int NCH  = 3,
    parameter int NREG = 8,
    parameter int DW   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_rst_n,
    input logic                       spi_cs_n,
    input logic                       spi_sdo,
    input logic                       spi_sdo_oe,
    input logic [NCH-1:0]             tx_off,
    input logic [NCH-1:0]             tx_ones,
    input logic [NCH-1:0]             tx_clkinv,
    input logic [NCH-1:0]             tx_lev,
    input logic [NCH-1:0]             tx_bin,
    input logic [NCH*(NREG-2)*DW-1:0] cfg_regs
);
    logic [2:0] since_rst;
    logic [3:0] cs_hi;
    logic [3:0] cs_lo;

    // Saturating counters: cycles since reset, consecutive idle and active select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            cs_hi     <= '0;
            cs_lo     <= '0;
        end else begin
            if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
            cs_hi <= spi_cs_n  ? ((cs_hi == 4'hf) ? cs_hi : cs_hi + 1'b1) : 4'h0;
            cs_lo <= !spi_cs_n ? ((cs_lo == 4'hf) ? cs_lo : cs_lo + 1'b1) : 4'h0;
        end
    end

    // R10: enable drops once the select has been idle long enough
    a_r10_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && cs_hi >= 4'd4) |-> !spi_sdo_oe);

    // R10: enable is up during a held select
    a_r10_oe_active: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && cs_lo >= 4'd4) |-> spi_sdo_oe);

    // R10 / R1: data output is quiet while idle
    a_r10_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && cs_hi >= 4'd5) |-> !spi_sdo);

    // R8: no register change while the select is idle and no register reset
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && cs_hi >= 4'd6 && reg_rst_n && $past(reg_rst_n))
        |-> ($stable(tx_off) && $stable(tx_ones) && $stable(tx_clkinv)
             && $stable(tx_lev) && $stable(tx_bin) && $stable(cfg_regs)));

    // R9: register reset clears every writable register on the next edge
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && $past(!reg_rst_n))
        |-> (tx_off == '0 && tx_ones == '0 && tx_clkinv == '0 && tx_lev == '0
             && tx_bin == '0 && cfg_regs == '0));
endmodule

bind sra_port sra_port_chk #(.NCH(NCH), .NREG(NREG), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rst_n  (reg_rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe),
    .tx_off     (tx_off),
    .tx_ones    (tx_ones),
    .tx_clkinv  (tx_clkinv),
    .tx_lev     (tx_lev),
    .tx_bin     (tx_bin),
    .cfg_regs   (cfg_regs)
);

// File: tb/sra_port_tb.sv
// Bench: random and directed serial frames checked against a register model.
module sra_port_tb;
    localparam int NCH = 3;
    localparam int NCF = 6;
    localparam int H   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_rst_n = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [NCH-1:0] a_lol = '0, a_los = '0, a_alos = '0, a_dlos = '0, a_dmo = '0;
    logic [NCH-1:0] tx_off, tx_ones, tx_clkinv, tx_lev, tx_bin;
    logic [NCH*NCF*8-1:0] cfg_regs;

    int nchk = 0;
    int nerr = 0;
    logic [4:0] m1 [NCH];
    logic [7:0] mc [NCH][NCF];

    always #10 clk = ~clk;

    sra_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_rst_n(reg_rst_n),
        .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
        .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
        .alm_lol(a_lol), .alm_los(a_los), .alm_alos(a_alos),
        .alm_dlos(a_dlos), .alm_dmo(a_dmo),
        .tx_off(tx_off), .tx_ones(tx_ones), .tx_clkinv(tx_clkinv),
        .tx_lev(tx_lev), .tx_bin(tx_bin), .cfg_regs(cfg_regs)
    );

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected read value per R3, R4, R5, R6
    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        int c = int'(a[5:3]);
        int s = int'(a[2:0]);
        if (c >= NCH) return 8'h00;
        if (s == 0) return {3'b000, a_lol[c], a_los[c], a_alos[c], a_dlos[c], a_dmo[c]};
        if (s == 1) return {3'b000, m1[c]};
        return mc[c][s-2];
    endfunction

    // Model update for a complete write frame
    task automatic model_wr(input logic [5:0] a, input logic [7:0] d);
        int c = int'(a[5:3]);
        int s = int'(a[2:0]);
        if (c < NCH) begin
            if (s == 1) m1[c] = d[4:0];
            else if (s >= 2) mc[c][s-2] = d;
        end
    endtask

    task automatic model_clr();
        for (int c = 0; c < NCH; c++) begin
            m1[c] = '0;
            for (int r = 0; r < NCF; r++) mc[c][r] = '0;
        end
    endtask

    // R5, R6: compare every control output with the model
    task automatic chk_outs(input string req);
        logic [NCH-1:0] e_off, e_ones, e_inv, e_lev, e_bin;
        logic [NCH*NCF*8-1:0] e_cfg;
        for (int c = 0; c < NCH; c++) begin
            e_bin[c] = m1[c][0]; e_lev[c] = m1[c][1]; e_inv[c] = m1[c][2];
            e_ones[c] = m1[c][3]; e_off[c] = m1[c][4];
            for (int r = 0; r < NCF; r++) e_cfg[(c*NCF + r)*8 +: 8] = mc[c][r];
        end
        chk({req, " R5 ctl"}, {17'd0, tx_off, tx_ones, tx_clkinv, tx_lev, tx_bin},
            {17'd0, e_off, e_ones, e_inv, e_lev, e_bin});
        for (int k = 0; k < NCH*NCF; k++)
            chk({req, " R6 cfg"}, {24'd0, cfg_regs[k*8 +: 8]}, {24'd0, e_cfg[k*8 +: 8]});
    endtask

    // One frame of nbits rising edges; frame bits per R2, read bits sampled per R7
    task automatic xfer(input logic rd, input logic [5:0] a, input logic [7:0] d,
                        input int nbits, output logic [7:0] q);
        q = '0;
        cs_n = 1'b0;
        wcyc(H);
        for (int i = 0; i < nbits; i++) begin
            if (i == 0) sdi = rd;
            else if (i <= 6) sdi = a[i-1];
            else if (i == 7) sdi = 1'($urandom);
            else if (i < 16) sdi = d[i-8];
            else sdi = 1'($urandom);
            wcyc(H);
            if (i >= 8 && i < 16) q[i-8] = sdo;
            sclk = 1'b1;
            wcyc(H);
            sclk = 1'b0;
        end
        wcyc(H);
        cs_n = 1'b1;
        wcyc(2*H);
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a);
        logic [7:0] q, e;
        e = exp_rd(a);
        xfer(1'b1, a, 8'h00, 16, q);
        chk(req, {24'd0, q}, {24'd0, e});
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] q;
        xfer(1'b0, a, d, 16, q);
        model_wr(a, d);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [7:0] q;
        model_clr();
        void'($urandom(32'h5eed_c0de));
        wcyc(4);
        rst_n = 1'b1;
        wcyc(4);

        // Reset state
        chk("R9 reset sdo_oe", {31'd0, sdo_oe}, 32'd0);
        chk("R10 reset sdo", {31'd0, sdo}, 32'd0);
        chk_outs("R9 reset");

        // R10: enable follows the select, data stays quiet when idle
        cs_n = 1'b0; wcyc(6);
        chk("R10 oe low-select", {31'd0, sdo_oe}, 32'd1);
        cs_n = 1'b1; wcyc(6);
        chk("R10 oe idle", {31'd0, sdo_oe}, 32'd0);
        chk("R10 sdo idle", {31'd0, sdo}, 32'd0);
        chk_outs("R1 empty frame");

        // R2, R5: LSB-first order into slot 1 of channel 0
        wr(6'd1, 8'h01);
        chk("R2 R5 bin bit0", {29'd0, tx_bin}, 32'h1);
        wr(6'd1, 8'hF0);
        chk("R5 off bit4", {29'd0, tx_off}, 32'h1);
        chk("R5 bin cleared", {29'd0, tx_bin}, 32'h0);
        rd_chk("R5 masked upper bits", 6'd1);

        // R3, R6: channel decode and slot placement
        wr(6'd9, 8'h0A);
        wr(6'd23, 8'hC3);
        wr(6'd18, 8'h5A);
        chk_outs("R3 R6 mapping");
        rd_chk("R6 readback ch2 s7", 6'd23);
        rd_chk("R3 readback ch1 s1", 6'd9);

        // R3: unmapped writes ignored, reads zero
        wr(6'd26, 8'hFF);
        wr(6'd63, 8'hFF);
        chk_outs("R3 unmapped write");
        rd_chk("R3 unmapped read 24", 6'd24);
        rd_chk("R3 unmapped read 63", 6'd63);

        // R4: status view and write rejection
        a_lol = 3'b001; a_los = 3'b010; a_alos = 3'b100; a_dlos = 3'b011; a_dmo = 3'b110;
        wcyc(2);
        rd_chk("R4 status ch0", 6'd0);
        rd_chk("R4 status ch1", 6'd8);
        wr(6'd16, 8'hFF);
        chk_outs("R4 write to slot 0");
        rd_chk("R4 status ch2", 6'd16);

        // R1, R8: short frames change nothing
        xfer(1'b0, 6'd2, 8'hEE, 15, q);
        chk_outs("R1 R8 frame 15 bits");
        xfer(1'b0, 6'd1, 8'h1F, 10, q);
        chk_outs("R1 frame 10 bits");
        // R2: extra bits after the 16th are ignored
        xfer(1'b0, 6'd3, 8'h77, 19, q);
        model_wr(6'd3, 8'h77);
        chk_outs("R2 long frame");

        // Random frames
        for (int n = 0; n < 70; n++) begin
            logic [5:0] a;
            logic [7:0] d;
            {a_lol, a_los, a_alos, a_dlos, a_dmo} = 15'($urandom);
            a = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'($urandom_range(0, 23));
            d = 8'($urandom);
            wcyc(2);
            if ($urandom_range(0, 1) == 1) rd_chk("R7 random read", a);
            else wr(a, d);
            chk_outs("R8 random");
        end

        // R9: register reset clears all writable registers
        wr(6'd1, 8'h1F);
        wr(6'd12, 8'hA5);
        reg_rst_n = 1'b0;
        wcyc(1);
        reg_rst_n = 1'b1;
        model_clr();
        wcyc(1);
        chk_outs("R9 register reset");
        rd_chk("R9 readback after clear", 6'd12);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule